// File: doc/BRIEF.md
# Command Response Capture Buffer

After a host issues a command to a memory card, the card answers on the command line with a 48-bit or 136-bit frame. This block takes those bits one at a time from a command-line receiver and keeps them. Software then collects them as a series of 16-bit reads from one read port. The block records two error conditions. The first is a timeout, raised when no start bit arrives within a programmable number of card-clock ticks. The second is a CRC error, raised when the external CRC checker reports a mismatch on a response type that is checked. A level signal marks the end of the response phase. It stays set until the next command starts.

A two-bit response kind arrives with the command-start strobe. Code 0 means no response is expected. Code 1 is a short frame with CRC checking. Code 2 is a long frame. Code 3 is a short frame without CRC checking. A short frame is stored whole, start bit included, as three words. The 32-bit card status therefore spans all three words and is recovered as (w0<<24)|(w1<<8)|(w2>>8). A long frame drops its first eight bits and keeps the following 128 as eight words, most significant word first, so each consecutive pair of words forms one 32-bit value.

Serial bits enter on a valid/ready stream. The receiver holds `rx_valid` and `rx_bit` until `rx_ready` is high, and a bit is consumed only in a cycle where both are high. `rx_ready` is high only while the block is waiting for a start bit or receiving a frame. Bits offered at any other time are not consumed. Words leave through a plain pop strobe, and `rd_data` always shows the word at the current read position.

Top module: `rsp_capture`

## Requirements
- R1: The response kind sampled with `cmd_start` selects the frame: 0 finishes at once with `resp_done` set in the next cycle and no words stored; 1 and 3 store 48 bits as 3 words; 2 stores 8 words.
- R2: For a short frame the words are the received bits most significant first, start bit at bit 15 of word 0, so the card status equals (w0<<24)|(w1<<8)|(w2>>8) truncated to 32 bits.
- R3: For a long frame the first 8 received bits are discarded, and word i holds received bits 8+16i to 23+16i, earliest bit at bit 15.
- R4: Each `rd_pop` advances the read position. `rd_data` is zero at any position at or beyond the stored word count, and it is zero before a frame completes.
- R5: `cmd_start` clears the read position, the stored word count and all three flags, and it overrides any capture in progress.
- R6: `resp_crc_err` is set at frame completion only for kind 1 when `crc_ok` is low together with the final bit. For kinds 2 and 3 it stays low whatever `crc_ok` is.
- R7: While a start bit is awaited, each `card_tick` is counted. On the tick that brings the count to the limit, `resp_timeout` and `resp_done` rise together and `resp_crc_err` stays low.
- R8: The timeout limit resets to 255 ticks and is replaced by `lim_wdata` when `lim_we` is high.
- R9: While a start bit is awaited, bits of value 1 are consumed and discarded. A 0 bit is the start bit and is stored as the first bit of the frame.
- R10: `rx_ready` is high only between a command start with a non-zero kind and completion or timeout. It is never high while `resp_done` is high.
- R11: `resp_done` rises in the cycle after the final frame bit is consumed, stays low before that, and holds until the next `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a command has been sent and its response is expected |
| cmd_kind | input | 2 | Response kind, sampled with `cmd_start` (0 none, 1 short+CRC, 2 long, 3 short raw) |
| card_tick | input | 1 | One pulse per card clock period, used for timeout counting |
| lim_we | input | 1 | Write strobe for the timeout limit |
| lim_wdata | input | 8 | New timeout limit in card ticks |
| rx_valid | input | 1 | Serial bit available |
| rx_ready | output | 1 | Block accepts a serial bit this cycle |
| rx_bit | input | 1 | Serial command-line bit |
| crc_ok | input | 1 | External CRC checker result, valid with the final bit |
| resp_done | output | 1 | Response phase over (received, timed out, or none expected) |
| resp_timeout | output | 1 | No start bit within the limit |
| resp_crc_err | output | 1 | CRC mismatch on a checked response |
| rd_pop | input | 1 | Advance to the next stored word |
| rd_data | output | 16 | Word at the current read position, zero past the end |

## Verification
A checked short frame is driven with idle 1 bits before its start bit. This separates skipping idle bits from storing them, and it confirms the byte-offset word layout through the recovered card status. A long frame shows that the header byte is discarded and that word order is preserved. The same frame shape is sent under kinds 1, 2 and 3 with a failing CRC result, which separates checked kinds from unchecked ones. Timeout runs at the reset limit and at a written limit probe the tick one before the boundary and the boundary tick itself. Bits offered after completion and pops past the end test that back-pressure and zero fill hold.

// File: rtl/rsp_cap_pkg.sv
package rsp_cap_pkg;
  typedef enum logic [1:0] {
    RK_NONE      = 2'd0,
    RK_SHORT_CRC = 2'd1,
    RK_LONG      = 2'd2,
    RK_SHORT_RAW = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WAIT = 2'd1,
    CS_RECV = 2'd2
  } cap_state_e;
endpackage

// File: rtl/rsp_timeout_ctr.sv
module rsp_timeout_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + (CNT_W+1)'(1);
  assign expired  = run && tick && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clear)                  cnt <= '0;
    else if (run && tick && !expired) cnt <= next_cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/rsp_shift_reg.sv
module rsp_shift_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clear) q <= '0;
    else if (shift) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/rsp_word_port.sv
module rsp_word_port #(
  parameter int WORD_W     = 16,
  parameter int STORE_W    = 128,
  parameter int SHORT_BITS = 48,
  parameter int PTR_W      = 4
) (
  input  logic [STORE_W-1:0] store,
  input  logic               is_long,
  input  logic [PTR_W-1:0]   ptr,
  input  logic [PTR_W-1:0]   nwords,
  output logic [WORD_W-1:0]  word
);
  localparam int LONG_WORDS  = STORE_W / WORD_W;
  localparam int SHORT_WORDS = SHORT_BITS / WORD_W;

  logic [WORD_W-1:0] lw [LONG_WORDS];
  logic [WORD_W-1:0] sw [SHORT_WORDS];

  generate
    for (genvar g = 0; g < LONG_WORDS; g++) begin : g_long
      assign lw[g] = store[STORE_W-1-WORD_W*g -: WORD_W];
    end
    for (genvar g = 0; g < SHORT_WORDS; g++) begin : g_short
      assign sw[g] = store[SHORT_BITS-1-WORD_W*g -: WORD_W];
    end
  endgenerate

  always_comb begin
    word = '0;
    if (ptr < nwords) begin
      if (is_long) begin
        for (int i = 0; i < LONG_WORDS; i++)
          if (ptr == PTR_W'(i)) word = lw[i];
      end else begin
        for (int i = 0; i < SHORT_WORDS; i++)
          if (ptr == PTR_W'(i)) word = sw[i];
      end
    end
  end
endmodule

// File: rtl/rsp_capture.sv
module rsp_capture
  import rsp_cap_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136,
  parameter int LONG_SKIP  = 8,
  parameter int TO_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_kind,
  input  logic              card_tick,
  input  logic              lim_we,
  input  logic [TO_W-1:0]   lim_wdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_bit,
  input  logic              crc_ok,
  output logic              resp_done,
  output logic              resp_timeout,
  output logic              resp_crc_err,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rd_data
);
  localparam int STORE_W     = LONG_BITS - LONG_SKIP;
  localparam int LONG_WORDS  = STORE_W / WORD_W;
  localparam int SHORT_WORDS = SHORT_BITS / WORD_W;
  localparam int BC_W        = $clog2(LONG_BITS + 1);
  localparam int PTR_W       = $clog2(LONG_WORDS + 1);

  cap_state_e        state;
  rsp_kind_e         kind_q;
  rsp_kind_e         kind_in;
  logic [BC_W-1:0]   bitcnt;
  logic [BC_W-1:0]   bit_last;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  nwords;
  logic [TO_W-1:0]   limit_q;
  logic [STORE_W-1:0] store;
  logic              take;
  logic              start_seen;
  logic              shift_en;
  logic              expired;

  assign kind_in    = rsp_kind_e'(cmd_kind);
  assign rx_ready   = (state == CS_WAIT) || (state == CS_RECV);
  assign take       = rx_valid && rx_ready;
  assign start_seen = take && (state == CS_WAIT) && !rx_bit;
  assign shift_en   = !cmd_start && (start_seen || (take && state == CS_RECV));
  assign bit_last   = (kind_q == RK_LONG) ? BC_W'(LONG_BITS - 1) : BC_W'(SHORT_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      limit_q <= '1;
    else if (lim_we) limit_q <= lim_wdata;
  end

  rsp_timeout_ctr #(.CNT_W(TO_W)) u_to (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cmd_start),
    .run     (state == CS_WAIT && !start_seen),
    .tick    (card_tick),
    .limit   (limit_q),
    .expired (expired)
  );

  rsp_shift_reg #(.W(STORE_W)) u_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd_start),
    .shift (shift_en),
    .din   (rx_bit),
    .q     (store)
  );

  rsp_word_port #(
    .WORD_W(WORD_W), .STORE_W(STORE_W), .SHORT_BITS(SHORT_BITS), .PTR_W(PTR_W)
  ) u_port (
    .store   (store),
    .is_long (kind_q == RK_LONG),
    .ptr     (ptr),
    .nwords  (nwords),
    .word    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= CS_IDLE;
      kind_q       <= RK_NONE;
      bitcnt       <= '0;
      ptr          <= '0;
      nwords       <= '0;
      resp_done    <= 1'b0;
      resp_timeout <= 1'b0;
      resp_crc_err <= 1'b0;
    end else if (cmd_start) begin
      state        <= (kind_in == RK_NONE) ? CS_IDLE : CS_WAIT;
      kind_q       <= kind_in;
      bitcnt       <= '0;
      ptr          <= '0;
      nwords       <= '0;
      resp_done    <= (kind_in == RK_NONE);
      resp_timeout <= 1'b0;
      resp_crc_err <= 1'b0;
    end else begin
      if (rd_pop && ptr < PTR_W'(LONG_WORDS)) ptr <= ptr + 1'b1;
      case (state)
        CS_WAIT: begin
          if (start_seen) begin
            state  <= CS_RECV;
            bitcnt <= BC_W'(1);
          end else if (expired) begin
            state        <= CS_IDLE;
            resp_done    <= 1'b1;
            resp_timeout <= 1'b1;
          end
        end
        CS_RECV: begin
          if (take) begin
            if (bitcnt == bit_last) begin
              state        <= CS_IDLE;
              resp_done    <= 1'b1;
              nwords       <= (kind_q == RK_LONG) ? PTR_W'(LONG_WORDS) : PTR_W'(SHORT_WORDS);
              resp_crc_err <= (kind_q == RK_SHORT_CRC) && !crc_ok;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsp_capture_chk.sv
module rsp_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic [1:0]  cmd_kind,
  input logic        rx_ready,
  input logic        resp_done,
  input logic        resp_timeout,
  input logic        resp_crc_err,
  input logic [15:0] rd_data
);
  // R10
  ready_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> !rx_ready);
  // R7
  timeout_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_timeout |-> (resp_done && !resp_crc_err));
  // R4
  zero_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_done |-> (rd_data == 16'h0000));
  // R5
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_kind != 2'd0) |=> (!resp_done && !resp_timeout && !resp_crc_err && rx_ready));
  // R1
  none_kind_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_kind == 2'd0) |=> (resp_done && !rx_ready && rd_data == 16'h0000));
  // R11
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && !cmd_start) |=> resp_done);
endmodule

bind rsp_capture rsp_capture_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_start    (cmd_start),
  .cmd_kind     (cmd_kind),
  .rx_ready     (rx_ready),
  .resp_done    (resp_done),
  .resp_timeout (resp_timeout),
  .resp_crc_err (resp_crc_err),
  .rd_data      (rd_data)
);

// File: tb/tb_rsp_capture.sv
`timescale 1ns/1ps
module tb_rsp_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic        card_tick = 1'b0;
  logic        lim_we = 1'b0;
  logic [7:0]  lim_wdata = 8'd0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        rx_bit = 1'b1;
  logic        crc_ok = 1'b1;
  logic        resp_done, resp_timeout, resp_crc_err;
  logic        rd_pop = 1'b0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] got[8];

  always #2 clk = ~clk;

  rsp_capture dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .card_tick(card_tick), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit), .crc_ok(crc_ok),
    .resp_done(resp_done), .resp_timeout(resp_timeout), .resp_crc_err(resp_crc_err),
    .rd_pop(rd_pop), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic [1:0] k);
    cmd_start = 1'b1; cmd_kind = k;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rx_valid = 1'b1; rx_bit = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_bit = 1'b1;
  endtask

  // driver: short frame, expected words pushed to the scoreboard
  task automatic send_short(input logic [47:0] v, input logic ok);
    for (int i = 0; i < 3; i++) exp_q.push_back(v[47-16*i -: 16]);
    crc_ok = ok;
    for (int i = 47; i >= 0; i--) begin
      send_bit(v[i]);
      if (i == 1) chk("R11 not done before final bit", resp_done, 1'b0);
    end
    crc_ok = 1'b1;
  endtask

  task automatic send_long(input logic [135:0] v, input logic ok);
    for (int i = 0; i < 8; i++) exp_q.push_back(v[127-16*i -: 16]);
    crc_ok = ok;
    for (int i = 135; i >= 0; i--) send_bit(v[i]);
    crc_ok = 1'b1;
  endtask

  // monitor: pop words and compare to the scoreboard
  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() > 0) begin
      logic [15:0] e = exp_q.pop_front();
      chk(req, rd_data, e);
      if (n < 8) got[n] = rd_data;
      n++;
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    chk("R4 pop past end reads zero", rd_data, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0]  s1, s3;
    logic [135:0] lg;
    logic [31:0]  st;
    s1 = {2'b00, 6'd17, 32'hC0DE_1234, 7'h55, 1'b1};
    s3 = {2'b00, 6'd41, 32'h0000_0900, 7'h2A, 1'b1};
    lg = {8'h3F, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset rx_ready", rx_ready, 1'b0);
    chk("R11 reset done", resp_done, 1'b0);
    chk("R4 reset rd_data", rd_data, 16'h0);

    // R1 kind 0: done at once, nothing stored
    start_cmd(2'd0);
    chk("R1 kind0 done", resp_done, 1'b1);
    chk("R10 kind0 not ready", rx_ready, 1'b0);
    chk("R4 kind0 reads zero", rd_data, 16'h0);

    // R9 idle ones skipped, R2 short layout
    start_cmd(2'd1);
    chk("R5 start clears done", resp_done, 1'b0);
    chk("R10 ready while waiting", rx_ready, 1'b1);
    repeat (3) send_bit(1'b1);
    chk("R9 idle bits not a start", resp_done, 1'b0);
    send_short(s1, 1'b1);
    chk("R11 done after frame", resp_done, 1'b1);
    chk("R6 good crc no error", resp_crc_err, 1'b0);
    chk("R10 not ready after done", rx_ready, 1'b0);
    send_bit(1'b0);
    chk("R10 extra bit not taken", rd_data, s1[47:32]);
    drain("R2 short word");
    st = ({16'h0, got[0]} << 24) | ({16'h0, got[1]} << 8) | ({16'h0, got[2]} >> 8);
    chk("R2 recovered card status", st, 32'hC0DE_1234);

    // R6 kind 1 with failing CRC
    start_cmd(2'd1);
    send_short(s3, 1'b0);
    chk("R6 kind1 crc error", resp_crc_err, 1'b1);
    chk("R7 no timeout on crc error", resp_timeout, 1'b0);
    drain("R5 read restarts at word 0");

    // R6 kind 3 ignores CRC
    start_cmd(2'd3);
    send_short(s1, 1'b0);
    chk("R6 kind3 no crc error", resp_crc_err, 1'b0);
    drain("R1 kind3 three words");

    // R3 long frame, kind 2 ignores CRC
    start_cmd(2'd2);
    send_long(lg, 1'b0);
    chk("R11 long done", resp_done, 1'b1);
    chk("R6 kind2 no crc error", resp_crc_err, 1'b0);
    drain("R3 long word");

    // R5 restart mid-capture
    start_cmd(2'd1);
    for (int i = 47; i >= 30; i--) send_bit(s3[i]);
    start_cmd(2'd3);
    chk("R5 restart clears", resp_done, 1'b0);
    send_short(s1, 1'b1);
    drain("R5 restarted frame word");

    // R8 default limit 255, R7 timeout
    start_cmd(2'd1);
    card_tick = 1'b1;
    repeat (254) @(negedge clk);
    chk("R8 no timeout at 254 ticks", resp_done, 1'b0);
    @(negedge clk);
    card_tick = 1'b0;
    chk("R8 timeout at 255 ticks", resp_timeout, 1'b1);
    chk("R7 done on timeout", resp_done, 1'b1);
    chk("R7 no crc on timeout", resp_crc_err, 1'b0);
    chk("R10 not ready after timeout", rx_ready, 1'b0);
    send_bit(1'b0);
    chk("R4 nothing stored after timeout", rd_data, 16'h0);

    // R8 written limit
    lim_we = 1'b1; lim_wdata = 8'd5;
    @(negedge clk);
    lim_we = 1'b0;
    start_cmd(2'd3);
    card_tick = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 no timeout at 4 of 5", resp_timeout, 1'b0);
    @(negedge clk);
    card_tick = 1'b0;
    chk("R7 timeout at limit 5", resp_timeout, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule